// File: doc/BRIEF.md
# SD SPI Block Transfer Engine

This engine moves a single data block between a local byte stream and a memory card that runs in SPI mode. It starts once a separate command engine has already issued the read-block or write-block command. It owns chip select for the data phase. It talks to the serial side through a byte-exchange port: it offers one byte to shift out, and the exchange partner returns the byte that was shifted in at the same time.

For a read, the engine clocks idle bytes until the card's start token appears. It then passes the payload bytes to a valid/ready output stream and drops the two checksum bytes that follow. For a write, it sends the start token. It then sends the payload, which it takes from a valid/ready input stream, and two filler bytes in place of the checksum. Next it reads and classifies the card's data-response token and waits while the card reports busy. Every transfer ends with chip select released and one trailing idle byte, and then a one-cycle done pulse carries a result code.

The payload length is set for each transfer. The same engine therefore handles a full 512-byte sector or a 16-byte register block. The start-token search and the busy wait each have a parameter that bounds them, so a silent card ends the transfer with an error instead of stalling the engine forever.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, and whenever no transfer is running, chip select is high, no exchange is requested, busy is low, and neither stream handshake is offered.
- R2: On a read, each exchange in the search phase sends 0xFF with chip select low, until a received byte equals 0xFE. Bytes received before the 0xFE never appear on the read stream.
- R3: On a read, exactly the programmed number of payload bytes that follow 0xFE leave on the read stream, in order. After them come two more exchanges that send 0xFF, and the bytes received in those two exchanges are not delivered.
- R4: No exchange is requested while a received read byte is still waiting for its consumer. A write payload byte is taken only when its producer offers it, and the bytes are sent in the order they are offered.
- R5: A write sends 0xFE, then the payload bytes in order, then two 0xFF bytes, all with chip select low.
- R6: After the write checksum bytes, one exchange sends 0xFF and masks the received byte with 0x1F. The value 0x05 means accepted. The value 0x0B ends the transfer with result code 2 (checksum rejected). The value 0x0D ends it with code 3 (write failed). Any other value ends it with code 4 (bad token). A rejected token skips the busy wait.
- R7: After an accepted token, exchanges keep sending 0xFF while the received byte is 0x00. The first nonzero byte ends the wait.
- R8: Every transfer ends with one exchange that sends 0xFF with chip select high. A done pulse follows, one cycle wide, with the result code valid. Code 0 means success.
- R9: If HUNT_MAX search exchanges all return bytes other than 0xFE, the read ends with code 1 and delivers no payload.
- R10: If BUSY_MAX busy-wait exchanges all return 0x00, the write ends with code 5.
- R11: A 0xFE on the last allowed search exchange, or a nonzero byte on the last allowed busy exchange, counts as success and not as a timeout.
- R12: The payload length is taken from len_i at start, so 16-byte and 512-byte blocks both transfer correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transfer (sampled while idle) |
| write_i | input | 1 | 1 = write block, 0 = read block |
| len_i | input | LEN_W | Payload length in bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Result is an error |
| err_code_o | output | 3 | Result code, valid with done_o |
| cs_no | output | 1 | Card chip select, active low |
| xchg_req_o | output | 1 | Byte exchange requested |
| xchg_tx_o | output | 8 | Byte to shift out |
| xchg_ack_i | input | 1 | Exchange complete, xchg_rx_i valid |
| xchg_rx_i | input | 8 | Byte shifted in |
| rd_valid_o | output | 1 | Read payload byte available |
| rd_data_o | output | 8 | Read payload byte |
| rd_ready_i | input | 1 | Consumer accepts read byte |
| wr_valid_i | input | 1 | Write payload byte offered |
| wr_data_i | input | 8 | Write payload byte |
| wr_ready_o | output | 1 | Engine accepts write byte |

## Verification
Two decisions can fall in the same exchange: the bound on the search or busy wait runs out, and the byte that ends the wait arrives. The bench provokes this by having the card model place 0xFE on exactly the HUNT_MAX-th search byte, and a nonzero byte on exactly the BUSY_MAX-th busy byte. The engine passes only if the result is success and the full payload is delivered. Transfers in which the bound runs out one byte earlier must instead end with codes 1 and 5, so the bench can tell an off-by-one in either direction.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HUNT, ST_RD_DATA, ST_RD_CRC,
    ST_WR_TOK, ST_WR_DATA, ST_WR_CRC, ST_WR_RESP, ST_WR_BUSY, ST_TAIL
  } xfer_st_e;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_HUNT_TO = 3'd1,
    E_CRC_REJ = 3'd2,
    E_WR_FAIL = 3'd3,
    E_BAD_TOK = 3'd4,
    E_BUSY_TO = 3'd5
  } xfer_err_e;

  typedef enum logic [1:0] {TK_ACCEPT, TK_CRC, TK_WRERR, TK_OTHER} tok_cls_e;

  localparam logic [7:0] START_TOK = 8'hFE;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] RESP_MASK = 8'h1F;
  localparam logic [7:0] RESP_OK   = 8'h05;
  localparam logic [7:0] RESP_CRC  = 8'h0B;
  localparam logic [7:0] RESP_WERR = 8'h0D;
endpackage

// File: rtl/sd_xfer_port.sv
module sd_xfer_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic [7:0] issue_byte_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic [7:0] tx_o,
  output logic       pending_o,
  output logic       done_o
);
  logic       req_q;
  logic [7:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      tx_q  <= 8'hFF;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
    end else if (issue_i && !req_q) begin
      req_q <= 1'b1;
      tx_q  <= issue_byte_i;
    end
  end

  assign req_o     = req_q;
  assign tx_o      = tx_q;
  assign pending_o = req_q;
  assign done_o    = req_q && ack_i;
endmodule

// File: rtl/sd_xfer_limit.sv
module sd_xfer_limit #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !hit_o)    cnt_q <= cnt_q + W'(1);
  end

  // high while the exchange in flight is the last one allowed
  assign hit_o = (cnt_q == LAST);
endmodule

// File: rtl/sd_xfer_tok.sv
module sd_xfer_tok
  import sd_xfer_pkg::*;
(
  input  logic [7:0] rx_i,
  output tok_cls_e   cls_o
);
  logic [7:0] masked;
  assign masked = rx_i & RESP_MASK;

  always_comb begin
    unique case (masked)
      RESP_OK:   cls_o = TK_ACCEPT;
      RESP_CRC:  cls_o = TK_CRC;
      RESP_WERR: cls_o = TK_WRERR;
      default:   cls_o = TK_OTHER;
    endcase
  end
endmodule

// File: rtl/sd_xfer_ctrl.sv
module sd_xfer_ctrl
  import sd_xfer_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             xdone_i,
  input  logic             pending_i,
  input  logic [7:0]       rx_i,
  input  tok_cls_e         tok_i,
  input  logic             hunt_hit_i,
  input  logic             busy_hit_i,
  output logic             issue_o,
  output logic [7:0]       issue_byte_o,
  output logic             cnt_clr_o,
  output logic             hunt_inc_o,
  output logic             busy_inc_o,
  output logic             cs_no,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       err_code_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  input  logic             rd_ready_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o
);
  xfer_st_e         state_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             crc_q;
  logic             rdv_q;
  logic [7:0]       rdd_q;
  xfer_err_e        err_q;
  logic             done_q;
  logic             last_pay;

  assign last_pay = (cnt_q == len_q - LEN_W'(1));

  always_comb begin
    issue_o      = 1'b0;
    issue_byte_o = FILL_BYTE;
    wr_ready_o   = 1'b0;
    unique case (state_q)
      ST_HUNT, ST_RD_DATA, ST_RD_CRC, ST_TAIL: issue_o = !pending_i && !rdv_q;
      ST_WR_TOK: begin
        issue_o      = !pending_i;
        issue_byte_o = START_TOK;
      end
      ST_WR_DATA: begin
        wr_ready_o   = !pending_i;
        issue_o      = wr_valid_i && !pending_i;
        issue_byte_o = wr_data_i;
      end
      ST_WR_CRC, ST_WR_RESP, ST_WR_BUSY: issue_o = !pending_i;
      default: ;
    endcase
  end

  assign cnt_clr_o  = (state_q == ST_IDLE) && start_i;
  assign hunt_inc_o = xdone_i && (state_q == ST_HUNT) && (rx_i != START_TOK);
  assign busy_inc_o = xdone_i && (state_q == ST_WR_BUSY) && (rx_i == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      crc_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= 8'h00;
      err_q   <= E_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready_i) rdv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          len_q   <= (len_i == '0) ? LEN_W'(1) : len_i;
          cnt_q   <= '0;
          crc_q   <= 1'b0;
          err_q   <= E_NONE;
          state_q <= write_i ? ST_WR_TOK : ST_HUNT;
        end
        ST_HUNT: if (xdone_i) begin
          // token wins over limit on the same byte
          if (rx_i == START_TOK) state_q <= ST_RD_DATA;
          else if (hunt_hit_i) begin
            err_q   <= E_HUNT_TO;
            state_q <= ST_TAIL;
          end
        end
        ST_RD_DATA: if (xdone_i) begin
          rdd_q <= rx_i;
          rdv_q <= 1'b1;
          if (last_pay) state_q <= ST_RD_CRC;
          else          cnt_q   <= cnt_q + LEN_W'(1);
        end
        ST_RD_CRC: if (xdone_i) begin
          crc_q <= 1'b1;
          if (crc_q) state_q <= ST_TAIL;
        end
        ST_WR_TOK: if (xdone_i) state_q <= ST_WR_DATA;
        ST_WR_DATA: if (xdone_i) begin
          if (last_pay) state_q <= ST_WR_CRC;
          else          cnt_q   <= cnt_q + LEN_W'(1);
        end
        ST_WR_CRC: if (xdone_i) begin
          crc_q <= 1'b1;
          if (crc_q) state_q <= ST_WR_RESP;
        end
        ST_WR_RESP: if (xdone_i) begin
          unique case (tok_i)
            TK_ACCEPT: state_q <= ST_WR_BUSY;
            TK_CRC:   begin err_q <= E_CRC_REJ; state_q <= ST_TAIL; end
            TK_WRERR: begin err_q <= E_WR_FAIL; state_q <= ST_TAIL; end
            default:  begin err_q <= E_BAD_TOK; state_q <= ST_TAIL; end
          endcase
        end
        ST_WR_BUSY: if (xdone_i) begin
          // ready wins over limit on the same byte
          if (rx_i != 8'h00) state_q <= ST_TAIL;
          else if (busy_hit_i) begin
            err_q   <= E_BUSY_TO;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: if (xdone_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no      = (state_q == ST_IDLE) || (state_q == ST_TAIL);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_code_o = err_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
  import sd_xfer_pkg::*;
#(
  parameter int MAX_LEN  = 512,
  parameter int HUNT_MAX = 64,
  parameter int BUSY_MAX = 4096,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic             cs_no,
  output logic             xchg_req_o,
  output logic [7:0]       xchg_tx_o,
  input  logic             xchg_ack_i,
  input  logic [7:0]       xchg_rx_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  input  logic             rd_ready_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o
);
  logic       issue, pending, xdone;
  logic [7:0] issue_byte;
  logic       cnt_clr, hunt_inc, busy_inc, hunt_hit, busy_hit;
  tok_cls_e   tok;

  sd_xfer_port u_port (
    .clk_i, .rst_ni,
    .issue_i(issue), .issue_byte_i(issue_byte), .ack_i(xchg_ack_i),
    .req_o(xchg_req_o), .tx_o(xchg_tx_o), .pending_o(pending), .done_o(xdone)
  );

  sd_xfer_limit #(.LIMIT(HUNT_MAX)) u_hunt_lim (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(hunt_inc), .hit_o(hunt_hit)
  );

  sd_xfer_limit #(.LIMIT(BUSY_MAX)) u_busy_lim (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(busy_inc), .hit_o(busy_hit)
  );

  sd_xfer_tok u_tok (.rx_i(xchg_rx_i), .cls_o(tok));

  sd_xfer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .write_i, .len_i,
    .xdone_i(xdone), .pending_i(pending), .rx_i(xchg_rx_i), .tok_i(tok),
    .hunt_hit_i(hunt_hit), .busy_hit_i(busy_hit),
    .issue_o(issue), .issue_byte_o(issue_byte),
    .cnt_clr_o(cnt_clr), .hunt_inc_o(hunt_inc), .busy_inc_o(busy_inc),
    .cs_no, .busy_o, .done_o, .err_code_o,
    .rd_valid_o, .rd_data_o, .rd_ready_i,
    .wr_valid_i, .wr_data_i, .wr_ready_o
  );

  assign err_o = (err_code_o != 3'd0);
endmodule

// File: rtl/sd_blk_xfer_chk.sv
module sd_blk_xfer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       cs_no,
  input logic       xchg_req_o,
  input logic [7:0] xchg_tx_o,
  input logic       xchg_ack_i,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       rd_ready_i,
  input logic       wr_ready_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !xchg_req_o && !rd_valid_o && !wr_ready_o));

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_req_o && !xchg_ack_i) |=> (xchg_req_o && $stable(xchg_tx_o)));

  assert_rd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_no_xchg_while_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !xchg_req_o);

  assert_wr_take_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> !xchg_req_o);

  assert_done_deselect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind sd_blk_xfer sd_blk_xfer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .cs_no(cs_no),
  .xchg_req_o(xchg_req_o), .xchg_tx_o(xchg_tx_o), .xchg_ack_i(xchg_ack_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ready_i(rd_ready_i),
  .wr_ready_o(wr_ready_o)
);

// File: tb/sd_blk_xfer_bench.sv
module sd_blk_xfer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HUNT_N = 8;
  localparam int BUSY_N = 12;
  localparam int LW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic start = 0, wr = 0;
  logic [LW-1:0] len = '0;
  logic busy, done, err, cs_n, req, ack = 0, rd_valid, rd_ready = 0, wr_valid = 0, wr_ready;
  logic [2:0] code;
  logic [7:0] tx, rx = 8'hFF, rd_data, wr_data = 8'h00;

  sd_blk_xfer #(.HUNT_MAX(HUNT_N), .BUSY_MAX(BUSY_N)) u_sd_blk_xfer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr), .len_i(len),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code), .cs_no(cs_n),
    .xchg_req_o(req), .xchg_tx_o(tx), .xchg_ack_i(ack), .xchg_rx_i(rx),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ready_i(rd_ready),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit stall_en = 0;
  logic [8:0] exp_q[$];
  logic [7:0] card_q[$];
  logic [7:0] rd_exp_q[$];
  logic [7:0] wr_src_q[$];
  int wr_idx = 0;
  bit took = 0;

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // card model: answers each exchange from the queues
  always @(negedge clk) begin
    if (!rst_n) ack = 0;
    else if (req && !ack) begin
      if (exp_q.size() == 0) chk(0, {tag, " extra exchange"}, tx, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(tx == e[7:0], {tag, " tx byte"}, tx, e[7:0]);
        chk(cs_n == e[8], {tag, " chip select"}, cs_n, e[8]);
      end
      rx  = (card_q.size() != 0) ? card_q.pop_front() : 8'hFF;
      ack = 1;
    end else ack = 0;
  end

  // read stream consumer
  always @(negedge clk) begin
    rd_ready = stall_en ? ((cyc % 5) > 1) : 1'b1;
    if (rd_valid && rd_ready) begin
      if (rd_exp_q.size() == 0) chk(0, {tag, " R2 R3 extra read byte"}, rd_data, 0);
      else begin
        logic [7:0] d;
        d = rd_exp_q.pop_front();
        chk(rd_data == d, {tag, " R3 read data"}, rd_data, d);
      end
    end
  end

  // write stream producer with gaps
  always @(negedge clk) begin
    if (took) wr_idx++;
    if (wr_idx < wr_src_q.size()) begin
      wr_valid = (cyc % 3) != 0;
      wr_data  = wr_src_q[wr_idx];
    end else wr_valid = 0;
    took = wr_valid && wr_ready;
  end

  task automatic clear_plan();
    exp_q.delete(); card_q.delete(); rd_exp_q.delete(); wr_src_q.delete();
    wr_idx = 0; took = 0;
  endtask

  task automatic plan_read(int n, int junk, bit tmo, int seed);
    clear_plan();
    for (int i = 0; i < junk; i++) begin
      exp_q.push_back({1'b0, 8'hFF});
      card_q.push_back((i % 3 == 0) ? 8'h01 : ((i % 3 == 1) ? 8'hFF : 8'h7F));
    end
    if (!tmo) begin
      exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'hFE);
      for (int i = 0; i < n; i++) begin
        logic [7:0] d;
        d = 8'((i * 7 + seed) & 255);
        exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(d); rd_exp_q.push_back(d);
      end
      exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'h12);
      exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'h34);
    end
    exp_q.push_back({1'b1, 8'hFF}); card_q.push_back(8'hFF);
  endtask

  task automatic plan_write(int n, logic [7:0] tok, int zeros, bit ready_byte, int seed);
    clear_plan();
    exp_q.push_back({1'b0, 8'hFE}); card_q.push_back(8'hFF);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((i * 13 + seed) & 255);
      wr_src_q.push_back(d);
      exp_q.push_back({1'b0, d}); card_q.push_back(8'hFF);
    end
    exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'hFF);
    exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'hFF);
    exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(tok);
    if ((tok & 8'h1F) == 8'h05) begin
      for (int i = 0; i < zeros; i++) begin
        exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'h00);
      end
      if (ready_byte) begin
        exp_q.push_back({1'b0, 8'hFF}); card_q.push_back(8'h80);
      end
    end
    exp_q.push_back({1'b1, 8'hFF}); card_q.push_back(8'hFF);
  endtask

  task automatic run(bit w, int n, int exp_code, string t);
    int k;
    tag = t;
    @(negedge clk); start = 1; wr = w; len = LW'(n);
    @(negedge clk); start = 0;
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk(done, {t, " R8 done seen"}, done, 1);
    chk(code == 3'(exp_code), {t, " R8 result code"}, code, exp_code);
    chk(err == (exp_code != 0), {t, " R8 error flag"}, err, exp_code != 0);
    chk(exp_q.size() == 0, {t, " R8 exchanges left"}, exp_q.size(), 0);
    chk(rd_exp_q.size() == 0, {t, " R3 read bytes left"}, rd_exp_q.size(), 0);
    if (w) chk(wr_idx == n, {t, " R4 write bytes taken"}, wr_idx, n);
    @(negedge clk);
    chk(!done && !busy && cs_n, {t, " R1 R8 back to idle"}, {done, busy, cs_n}, 3'b001);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !req && !busy && !rd_valid && !wr_ready && !done, "R1 reset state",
        {cs_n, req, busy, rd_valid, wr_ready, done}, 6'b100000);

    plan_read(16, 3, 0, 5);            run(0, 16, 0, "R2 R12 read16");
    stall_en = 1;
    plan_read(512, 1, 0, 9);           run(0, 512, 0, "R3 R4 R12 read512 stalled");
    stall_en = 0;
    plan_read(16, HUNT_N - 1, 0, 3);   run(0, 16, 0, "R11 token on last hunt byte");
    plan_read(16, HUNT_N, 1, 0);       run(0, 16, 1, "R9 hunt timeout");
    plan_write(16, 8'hE5, 3, 1, 1);    run(1, 16, 0, "R5 R7 write accepted");
    plan_write(20, 8'h05, 0, 1, 4);    run(1, 20, 0, "R4 R5 write no busy");
    plan_write(8, 8'hEB, 0, 0, 2);     run(1, 8, 2, "R6 crc rejected");
    plan_write(8, 8'hED, 0, 0, 6);     run(1, 8, 3, "R6 write failed");
    plan_write(8, 8'h07, 0, 0, 7);     run(1, 8, 4, "R6 bad token");
    plan_write(8, 8'h05, BUSY_N, 0, 8);     run(1, 8, 5, "R10 busy timeout");
    plan_write(8, 8'h05, BUSY_N - 1, 1, 9); run(1, 8, 0, "R11 ready on last busy byte");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule